// File: doc/BRIEF.md
# Lamp Fault Timeout Monitor

This block guards a backlight dimming controller against lamps that never strike. It watches an active-low lamp-status input: low means at least one lamp is dark. While that input stays low and the controller is enabled, the block counts pulses of a slow time-base tick. When the count reaches the value held in an 8-bit timeout setting, the block latches a fault. The fault raises a status flag and forces the dimming outputs off.

The timeout setting gives the duration in tick periods. Any value from 1 to 255 selects a finite timeout, and 0 turns the shutdown off. If the lamps come back before the timeout runs out, the count starts again from zero and nothing is recorded. A latched fault stays set for as long as the controller remains enabled. Dropping the global enable clears the fault, and raising it again resumes normal operation.

The lamp-status input comes from outside the clock domain. It passes through a short synchronizer before the counting logic sees it.

Top module: `lamp_fault_monitor`

## Requirements
- R1: After reset, `fault_o` is 0, the tick count is zero and the synchronizer reads the lamps as lit.
- R2: `lamp_ok_i` is active low (0 = a lamp is dark) and reaches the counter through SYNC_STAGES (default 2) flip-flops. With `tmo_val_i` = N (1..255), the tick held high and `lamp_ok_i` driven low, `fault_o` rises on clock edge SYNC_STAGES+N after the input change, and not before.
- R3: With `tmo_val_i` = 0 the block never raises a fault, however long the lamps stay dark.
- R4: If the synchronized lamp status returns high before expiry, the count clears. A low lasting L cycles (tick every cycle) faults only if L >= N, and the next low starts again from zero.
- R5: While `enable_i` is 0 no ticks are counted, the count is cleared, and `fault_o` is 0 from the edge after `enable_i` is seen low.
- R6: Once set, `fault_o` stays 1 while `enable_i` stays 1. Lamp recovery and changes to `tmo_val_i` do not clear it.
- R7: `out_disable_o` is 1 when `fault_o` is 1 or `enable_i` is 0, and 0 otherwise.
- R8: The comparison uses the current `tmo_val_i`. Lowering it to a value at or below the count already reached expires on the next tick. Raising it extends the run from the count already reached.
- R9: Only cycles with `tick_i` = 1 advance the count. With N = 4, the fault follows the edge that samples the fourth tick pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base pulse, one cycle wide per timeout unit |
| lamp_ok_i | input | 1 | Lamp status, low when a lamp is dark (asynchronous) |
| tmo_val_i | input | TMO_W | Timeout in ticks, 0 turns shutdown off |
| enable_i | input | 1 | Global controller enable |
| fault_o | output | 1 | Latched lamp fault status |
| out_disable_o | output | 1 | Forces dimming outputs low |

## Verification
The hardest states to reach are the expiry boundary at large timeouts and a threshold moved below a count that is already running. The bench sweeps every timeout value from 1 to 255 with a tick in every cycle. For each value it samples the edge before and the edge of expiry, which counts in the synchronizer latency. It then holds a long timeout partway and rewrites the setting to a smaller value and to a larger one. Separate runs use lows that end one cycle short of expiry and sparse single-cycle ticks to reach the restart and tick-gating corners.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

  // Expiry test: a non-zero timeout is reached when one more tick
  // would bring the count to the programmed value or beyond.
  function automatic logic tmo_reached(input int unsigned cnt,
                                       input int unsigned tmo);
    return (tmo != 0) && ((cnt + 1) >= tmo);
  endfunction

  // Dimming outputs are off when a fault is latched or the controller is off.
  function automatic logic outputs_off(input logic fault, input logic enable);
    return fault | ~enable;
  endfunction

endpackage

// File: rtl/lfm_sync.sv
module lfm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];

  // R2
  sync_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pipe_q[0]) |-> $past(d_i));
endmodule

// File: rtl/lfm_timer.sv
module lfm_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             lamp_low_i,
  input  logic             enable_i,
  input  logic             fault_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             expire_o
);
  localparam logic [TMO_W-1:0] CNT_TOP = {TMO_W{1'b1}};

  logic [TMO_W-1:0] cnt_q;
  logic             run;
  logic             reached;

  assign run      = enable_i && lamp_low_i && !fault_i && (tmo_i != '0);
  assign reached  = lfm_pkg::tmo_reached(32'(cnt_q), 32'(tmo_i));
  assign expire_o = run && tick_i && reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run)              cnt_q <= '0;
    else if (tick_i && !reached) cnt_q <= cnt_q + 1'b1;
  end

  // R3
  zero_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_i == '0) |-> !expire_o);
  // R4
  recover_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lamp_low_i |=> (cnt_q == '0));
  // R9
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && run) |=> $stable(cnt_q));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != CNT_TOP);
endmodule

// File: rtl/lfm_fault_latch.sv
module lfm_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic expire_i,
  output logic fault_o
);
  logic fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fault_q <= 1'b0;
    else if (!enable_i) fault_q <= 1'b0;
    else if (expire_i)  fault_q <= 1'b1;
  end

  assign fault_o = fault_q;

  // R6
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && enable_i) |=> fault_q);
  // R5
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !fault_q);
  // R2
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(expire_i));
endmodule

// File: rtl/lamp_fault_monitor.sv
module lamp_fault_monitor #(
  parameter int TMO_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             lamp_ok_i,
  input  logic [TMO_W-1:0] tmo_val_i,
  input  logic             enable_i,
  output logic             fault_o,
  output logic             out_disable_o
);
  logic lamp_ok_s;
  logic lamp_low_s;
  logic expire;
  logic fault;

  lfm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (lamp_ok_i),
    .q_o   (lamp_ok_s)
  );

  assign lamp_low_s = ~lamp_ok_s;

  lfm_timer #(.TMO_W(TMO_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .lamp_low_i (lamp_low_s),
    .enable_i   (enable_i),
    .fault_i    (fault),
    .tmo_i      (tmo_val_i),
    .expire_o   (expire)
  );

  lfm_fault_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable_i),
    .expire_i (expire),
    .fault_o  (fault)
  );

  assign fault_o       = fault;
  assign out_disable_o = lfm_pkg::outputs_off(fault, enable_i);

  // R7
  off_when_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> out_disable_o);
endmodule

// File: tb/sim_lamp_fault_monitor.sv
module sim_lamp_fault_monitor;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n, tick, lamp_ok, enable;
  logic [7:0] tmo;
  logic       fault, odis;
  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  lamp_fault_monitor #(.TMO_W(8), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .lamp_ok_i(lamp_ok),
    .tmo_val_i(tmo), .enable_i(enable), .fault_o(fault), .out_disable_o(odis)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic nwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rearm();
    enable = 1'b0; lamp_ok = 1'b1; tick = 1'b1;
    nwait(4);
    enable = 1'b1;
    nwait(1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual %0d expected below 200000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; lamp_ok = 1'b1; enable = 1'b0; tmo = 8'd5;
    nwait(3);
    rst_n = 1'b1;
    nwait(1);
    chk("R1 reset fault", int'(fault), 0);
    chk("R7 disabled while enable low", int'(odis), 1);

    enable = 1'b1;
    nwait(20);
    chk("R4 lit lamps no fault", int'(fault), 0);
    chk("R7 outputs on", int'(odis), 0);

    // R2 exhaustive timeout sweep, tick every cycle
    for (int n = 1; n <= 255; n++) begin
      rearm();
      tmo = 8'(n);
      lamp_ok = 1'b0;
      nwait(SYNC + n - 1);
      chk($sformatf("R2 before expiry n=%0d", n), int'(fault), 0);
      nwait(1);
      chk($sformatf("R2 at expiry n=%0d", n), int'(fault), 1);
      chk($sformatf("R7 off on fault n=%0d", n), int'(odis), 1);
      lamp_ok = 1'b1;
      nwait(3);
      chk($sformatf("R6 held after recovery n=%0d", n), int'(fault), 1);
      enable = 1'b0;
      nwait(1);
      chk($sformatf("R5 cleared by enable low n=%0d", n), int'(fault), 0);
    end

    // R3 zero timeout
    rearm();
    tmo = 8'd0;
    lamp_ok = 1'b0;
    nwait(600);
    chk("R3 zero timeout no fault", int'(fault), 0);
    chk("R3 outputs stay on", int'(odis), 0);

    // R4 recovery restarts count
    rearm();
    tmo = 8'd10;
    lamp_ok = 1'b0; nwait(9); lamp_ok = 1'b1; nwait(6);
    chk("R4 short low no fault", int'(fault), 0);
    lamp_ok = 1'b0; nwait(9); lamp_ok = 1'b1; nwait(6);
    chk("R4 restart from zero", int'(fault), 0);
    lamp_ok = 1'b0; nwait(10); lamp_ok = 1'b1; nwait(6);
    chk("R4 low equal to timeout faults", int'(fault), 1);

    // R5 counting suppressed while disabled
    enable = 1'b0; tmo = 8'd5; lamp_ok = 1'b0; tick = 1'b1;
    nwait(50);
    chk("R5 no fault while disabled", int'(fault), 0);
    chk("R7 off while disabled", int'(odis), 1);
    enable = 1'b1;
    nwait(4);
    chk("R5 count starts at enable", int'(fault), 0);
    nwait(1);
    chk("R5 fault after full timeout", int'(fault), 1);

    // R6 latch survives recovery and timeout change
    lamp_ok = 1'b1; tmo = 8'd0;
    nwait(30);
    chk("R6 fault latched", int'(fault), 1);
    chk("R7 outputs held off", int'(odis), 1);

    // R8 lowering the threshold mid-count
    rearm();
    tmo = 8'd200; lamp_ok = 1'b0;
    nwait(SYNC + 50);
    chk("R8 running below 200", int'(fault), 0);
    tmo = 8'd20;
    nwait(1);
    chk("R8 lowered threshold expires", int'(fault), 1);

    // R8 raising the threshold mid-count
    rearm();
    tmo = 8'd20; lamp_ok = 1'b0;
    nwait(SYNC + 10);
    tmo = 8'd40;
    nwait(29);
    chk("R8 raised threshold not yet", int'(fault), 0);
    nwait(1);
    chk("R8 raised threshold expires", int'(fault), 1);

    // R9 only tick cycles count
    rearm();
    tmo = 8'd4; tick = 1'b0; lamp_ok = 1'b0;
    nwait(100);
    chk("R9 no ticks no fault", int'(fault), 0);
    for (int i = 0; i < 3; i++) begin
      tick = 1'b1; nwait(1); tick = 1'b0; nwait(2);
    end
    chk("R9 three ticks short", int'(fault), 0);
    tick = 1'b1; nwait(1); tick = 1'b0;
    chk("R9 fourth tick expires", int'(fault), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule